// File: doc/BRIEF.md
# Multi-Port LUT-Style RAM

A small word-organised memory built from flip-flop-free table storage: one port writes on the rising clock edge and up to four ports read combinationally, each from its own address. The mode parameter decides how many ports are live. In single-port mode there is one read/write port. In dual-port mode a read-only port is added beside the read/write port. In simple-dual-port mode the first port only writes and a second port only reads. In quad mode one read/write port works alongside three independent read-only ports. The write address is always the address of port 0.

An optional output stage registers each live read result. This turns the asynchronous read into a synchronous one, at the price of exactly one cycle of latency. The stage's reset clears only those output registers and never the stored words. The stored words start at a fill value given by a parameter. Typical uses are register files with several operand reads, small lookup tables rewritten at run time, and shallow LUT FIFOs.

Top module: `mpram_lut`

## Requirements
- R1: When `we` is high at a rising edge of `clk`, `wdata` is stored at `addr0`. When `we` is low, no word changes.
- R2: With `REG_OUT=0`, each live `rdataN` shows the word at `addrN` combinationally. Port 0 shows a word written at `addr0` right after that write's edge.
- R3: With `REG_OUT=0`, a read-only port whose address equals `addr0` shows newly written data right after the write edge.
- R4: In quad mode, the four ports read four different addresses in the same cycle, each returning its own word.
- R5: In quad mode, two ports given the same address return the same data.
- R6: With `REG_OUT=1`, each live `rdataN` holds the word that was at `addrN` just before the previous rising edge. This is one cycle later than the unregistered read. A read during a write to the same address returns the old word.
- R7: The `MODE` encoding is 0 single, 1 dual, 2 simple-dual and 3 quad. Outputs of ports that a mode does not use are driven to zero: ports 1 to 3 in mode 0, ports 2 and 3 in mode 1, and ports 0, 2 and 3 in mode 2.
- R8: Every word starts equal to `INIT_WORD`. While `rst_n` is low, registered outputs read zero, and reset never alters stored words.
- R9: The whole depth is addressable. Address 0 and address `DEPTH-1` (63 by default) hold independent words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and output registers act on its rising edge |
| rst_n | input | 1 | Active-low synchronous clear of the registered read outputs |
| we | input | 1 | Write enable for port 0 |
| wdata | input | DW | Word to be written |
| addr0 | input | AW | Port 0 address, also the write address |
| addr1 | input | AW | Port 1 read address |
| addr2 | input | AW | Port 2 read address |
| addr3 | input | AW | Port 3 read address |
| rdata0 | output | DW | Port 0 read data |
| rdata1 | output | DW | Port 1 read data |
| rdata2 | output | DW | Port 2 read data |
| rdata3 | output | DW | Port 3 read data |

## Verification
An unregistered read changes at the edge that performs a write, so it is sampled 2 ns after that edge, before the inputs move. A registered read still shows the old word at that same sampling point. It shows the new word only after the following edge, and the bench samples both moments to pin the single cycle of latency. Input changes are also applied 2 ns after an edge, so every check falls in a settled window between edges.

// File: rtl/mpram_pkg.sv
package mpram_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'd0,
      MODE_DUAL   = 2'd1,
      MODE_SIMPLE = 2'd2,
      MODE_QUAD   = 2'd3
   } port_mode_e;

   localparam int unsigned NUM_PORTS = 4;

   // Whether a given port drives read data in a given mode
   function automatic bit port_live(input int unsigned mode, input int unsigned idx);
      case (mode)
         0:       return (idx == 0);
         1:       return (idx <= 1);
         2:       return (idx == 1);
         default: return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/mpram_store.sv
module mpram_store #(
   parameter int unsigned DW        = 4,
   parameter int unsigned DEPTH     = 64,
   parameter int unsigned AW        = 6,
   parameter int unsigned NRD       = 4,
   parameter logic [DW-1:0] INIT_WORD = '0
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DW-1:0]     wdata,
   input  logic [NRD*AW-1:0] raddr,
   output logic [NRD*DW-1:0] rword
);

   logic [DW-1:0] cells [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) cells[i] = INIT_WORD;
   end

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   for (genvar p = 0; p < NRD; p++) begin : g_tap
      assign rword[p*DW +: DW] = cells[raddr[p*AW +: AW]];
   end

endmodule

// File: rtl/mpram_rport.sv
module mpram_rport #(
   parameter int unsigned DW      = 4,
   parameter bit          REG_OUT = 1'b0,
   parameter bit          LIVE    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] comb_in,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) held_q <= '0;
      else        held_q <= comb_in;
   end

   always_comb begin
      if (!LIVE)        rdata = '0;
      else if (REG_OUT) rdata = held_q;
      else              rdata = comb_in;
   end

endmodule

// File: rtl/mpram_lut.sv
module mpram_lut
   import mpram_pkg::*;
#(
   parameter int unsigned   DW        = 4,
   parameter int unsigned   DEPTH     = 64,
   parameter int unsigned   MODE      = 3,
   parameter bit            REG_OUT   = 1'b0,
   parameter logic [DW-1:0] INIT_WORD = '0,
   localparam int unsigned  AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] addr0,
   input  logic [AW-1:0] addr1,
   input  logic [AW-1:0] addr2,
   input  logic [AW-1:0] addr3,
   output logic [DW-1:0] rdata0,
   output logic [DW-1:0] rdata1,
   output logic [DW-1:0] rdata2,
   output logic [DW-1:0] rdata3
);

   localparam int unsigned NP       = NUM_PORTS;
   localparam int unsigned MAX_BITS = 256;

   // Elaboration-time parameter checks
   if ((1 << AW) != DEPTH) begin : g_err_depth
      $error("mpram_lut: DEPTH must be a power of two");
   end
   if (DEPTH * DW > MAX_BITS) begin : g_err_size
      $error("mpram_lut: DEPTH*DW exceeds the cascade limit");
   end
   if (MODE > 3) begin : g_err_mode
      $error("mpram_lut: MODE must be 0..3");
   end

   logic [NP*AW-1:0] addr_bus;
   logic [NP*DW-1:0] word_bus;
   logic [DW-1:0]    port_q [NP];

   assign addr_bus = {addr3, addr2, addr1, addr0};

   mpram_store #(
      .DW(DW), .DEPTH(DEPTH), .AW(AW), .NRD(NP), .INIT_WORD(INIT_WORD)
   ) i_store (
      .clk   (clk),
      .we    (we),
      .waddr (addr0),
      .wdata (wdata),
      .raddr (addr_bus),
      .rword (word_bus)
   );

   for (genvar p = 0; p < NP; p++) begin : g_port
      mpram_rport #(
         .DW(DW), .REG_OUT(REG_OUT), .LIVE(port_live(MODE, p))
      ) i_rport (
         .clk     (clk),
         .rst_n   (rst_n),
         .comb_in (word_bus[p*DW +: DW]),
         .rdata   (port_q[p])
      );
   end

   assign rdata0 = port_q[0];
   assign rdata1 = port_q[1];
   assign rdata2 = port_q[2];
   assign rdata3 = port_q[3];

   // ---------------- assertions ----------------
   if (!REG_OUT && port_live(MODE, 0)) begin : g_chk_wr_comb
      assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
         we |=> ((addr0 != $past(addr0)) || (rdata0 == $past(wdata))));
   end

   if (REG_OUT && port_live(MODE, 0)) begin : g_chk_wr_reg
      assert_reg_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(we, 2) && !$past(we) && ($past(addr0) == $past(addr0, 2)) && (addr0 == $past(addr0)))
         |-> (rdata0 == $past(wdata, 2)));
   end

   if (!REG_OUT && port_live(MODE, 1)) begin : g_chk_hold
      assert_no_write_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (!$past(we) && $stable(addr1)) |-> $stable(rdata1));
   end

   if (MODE == 3) begin : g_chk_agree
      if (REG_OUT) begin : g_r
         assert_port_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(addr1) == $past(addr0)) |-> (rdata1 == rdata0));
      end else begin : g_c
         assert_port_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (addr2 == addr0) |-> (rdata2 == rdata0));
      end
   end

endmodule

// File: tb/test_mpram_lut.sv
module test_mpram_lut;

   localparam int unsigned DW   = 4;
   localparam int unsigned DEP  = 64;
   localparam int unsigned AW   = 6;
   localparam logic [DW-1:0] FILL = 4'hA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          we = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [AW-1:0] a0 = '0, a1 = '0, a2 = '0, a3 = '0;
   logic [DW-1:0] q0, q1, q2, q3;
   logic [DW-1:0] r0, r1, r2, r3;
   logic [DW-1:0] s0, s1, s2, s3;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [DW-1:0] model [DEP];

   always #5 clk = ~clk;

   mpram_lut #(.DW(DW), .DEPTH(DEP), .MODE(3), .REG_OUT(1'b0), .INIT_WORD(FILL)) i_mpram_lut (
      .clk(clk), .rst_n(rst_n), .we(we), .wdata(wdata),
      .addr0(a0), .addr1(a1), .addr2(a2), .addr3(a3),
      .rdata0(q0), .rdata1(q1), .rdata2(q2), .rdata3(q3));

   mpram_lut #(.DW(DW), .DEPTH(DEP), .MODE(3), .REG_OUT(1'b1), .INIT_WORD(FILL)) i_mpram_lut_reg (
      .clk(clk), .rst_n(rst_n), .we(we), .wdata(wdata),
      .addr0(a0), .addr1(a1), .addr2(a2), .addr3(a3),
      .rdata0(r0), .rdata1(r1), .rdata2(r2), .rdata3(r3));

   mpram_lut #(.DW(DW), .DEPTH(DEP), .MODE(2), .REG_OUT(1'b0), .INIT_WORD(FILL)) i_mpram_lut_sdp (
      .clk(clk), .rst_n(rst_n), .we(we), .wdata(wdata),
      .addr0(a0), .addr1(a1), .addr2(a2), .addr3(a3),
      .rdata0(s0), .rdata1(s1), .rdata2(s2), .rdata3(s3));

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one edge, then a settled sampling point 2 ns later
   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic set_addr(input int x0, input int x1, input int x2, input int x3);
      a0 = AW'(x0); a1 = AW'(x1); a2 = AW'(x2); a3 = AW'(x3);
   endtask

   task automatic write_word(input int adr, input logic [DW-1:0] d);
      we = 1'b1; a0 = AW'(adr); wdata = d;
      tick();
      model[adr] = d;
      we = 1'b0;
   endtask

   task automatic t_reset();
      set_addr(7, 7, 7, 7);
      repeat (3) tick();
      chk("R8 reg out cleared", r0, '0);
      chk("R8 reg out cleared p3", r3, '0);
      chk("R8 init word p0", q0, FILL);
      chk("R8 init word p3", q3, FILL);
      rst_n = 1'b1;
      tick();
      chk("R8 memory kept by reset", r1, FILL);
   endtask

   task automatic t_rw_all();
      set_addr(5, 5, 5, 5);
      we = 1'b1; wdata = 4'h3;
      tick();
      model[5] = 4'h3;
      we = 1'b0;
      chk("R2 port0 sees write", q0, 4'h3);
      chk("R3 port1 sees write", q1, 4'h3);
      chk("R3 port2 sees write", q2, 4'h3);
      chk("R3 port3 sees write", q3, 4'h3);
   endtask

   task automatic t_we_low();
      set_addr(5, 5, 5, 5);
      wdata = 4'hF;
      tick();
      chk("R1 we low no change", q0, model[5]);
      chk("R1 we low no change p2", q2, model[5]);
   endtask

   task automatic t_distinct();
      for (int i = 0; i < 4; i++) write_word(20 + i, DW'(i * 3 + 1));
      set_addr(20, 21, 22, 23);
      #1;
      chk("R4 p0", q0, model[20]);
      chk("R4 p1", q1, model[21]);
      chk("R4 p2", q2, model[22]);
      chk("R4 p3", q3, model[23]);
      set_addr(23, 22, 21, 20);
      #1;
      chk("R4 swapped p0", q0, model[23]);
      chk("R4 swapped p3", q3, model[20]);
   endtask

   task automatic t_equal();
      set_addr(21, 22, 21, 21);
      #1;
      chk("R5 equal addr p0 p2", q2, q0);
      chk("R5 equal addr p3", q3, model[21]);
   endtask

   task automatic t_registered();
      set_addr(9, 9, 9, 9);
      tick();
      we = 1'b1; wdata = 4'h6;
      tick();
      model[9] = 4'h6;
      we = 1'b0;
      chk("R6 read during write old", r0, FILL);
      chk("R6 read during write old p2", r2, FILL);
      chk("R2 comb already new", q0, 4'h6);
      tick();
      chk("R6 one cycle later p0", r0, 4'h6);
      chk("R6 one cycle later p3", r3, 4'h6);
      set_addr(9, 20, 21, 22);
      #1;
      chk("R6 reg holds before edge", r1, 4'h6);
      tick();
      chk("R6 new address after edge", r1, model[20]);
   endtask

   task automatic t_modes();
      set_addr(5, 21, 22, 23);
      #1;
      chk("R7 simple-dual p0 zero", s0, '0);
      chk("R7 simple-dual p2 zero", s2, '0);
      chk("R7 simple-dual p3 zero", s3, '0);
      chk("R7 simple-dual p1 reads", s1, model[21]);
   endtask

   task automatic t_bounds();
      write_word(0, 4'h1);
      write_word(DEP - 1, 4'hE);
      set_addr(0, DEP - 1, 0, DEP - 1);
      #1;
      chk("R9 low address", q0, 4'h1);
      chk("R9 top address", q1, 4'hE);
      chk("R9 top via p3", q3, 4'hE);
   endtask

   initial begin
      for (int i = 0; i < DEP; i++) model[i] = FILL;
      t_reset();
      t_rw_all();
      t_we_low();
      t_distinct();
      t_equal();
      t_registered();
      t_modes();
      t_bounds();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule